// File: doc/BRIEF.md
# Peripheral Bus Access Guard

This block decides, cycle by cycle, which peripherals on a shared two-wire serial bus may actually drive its data and clock lines. A privileged context programs a permission table: one row per application ID, with one bit per peripheral. The application that is running then writes a select register to switch on the peripherals it needs at the moment. The select register only accepts a subset of that application's row. A peripheral's active-low output enables for both lines are low only while its bit is set in both the permission row of the current application ID and the select register.

The guard also watches the bus lines. It flags a security exception when a transaction that opened with a START condition is not closed by a STOP within a fixed number of cycles. In that case it cuts every peripheral off the bus by clearing the select register. A panic input clears the select register as well. It also holds each peripheral that was enabled at that moment in reset for a fixed window. During that window the peripheral's enables stay high. The privileged context saves and restores the select register as part of the application's context, through a separate read/write port.

Top module: `periph_bus_guard`

## Requirements
- R1: After synchronous reset, every data and clock enable is high (inactive), every device reset is low, both exception outputs are low, `ctx_rdata` reads zero, and every permission row is zero.
- R2: A pulse on `cfg_we` writes `cfg_row` into the permission row of application `cfg_app`, where bit i stands for peripheral i. The rows of other applications do not change.
- R3: A write through `sel_we` whose `sel_data` has any bit set outside the current application's row is rejected. The select register keeps its value and `sec_exc_perm` is high for exactly the following cycle. A write that is a subset is stored and raises no exception.
- R4: For each peripheral i, `sda_oe_n[i]` and `scl_oe_n[i]` are both low exactly when bit i is set in the row of `app_id`, bit i is set in the select register, and peripheral i is not in its reset window. Changes to `app_id` or to the row take effect with no register delay.
- R5: `ctx_rdata` always shows the select register. `ctx_we` loads `ctx_wdata` without a permission check, wins over `sel_we` in the same cycle, and never raises `sec_exc_perm`.
- R6: A START is SDA going from 1 to 0 between two samples while SCL is 1 in both. A STOP is SDA going from 0 to 1 while SCL is 1 in both. An SDA change while SCL is low is neither.
- R7: Call the clock edge that samples a START edge 0. If no STOP is sampled by edge TXN_LIMIT, `sec_exc_len` is high for the single cycle after edge TXN_LIMIT and the select register then reads zero. A STOP sampled at edge TXN_LIMIT or earlier raises nothing.
- R8: When `panic` is sampled high, the select register is cleared. Every peripheral enabled at that edge has its `dev_rst` bit high for exactly RST_CYCLES cycles after that edge.
- R9: While `dev_rst[i]` is high, both enables of peripheral i stay high even if the select register is rewritten to include it. They go low again once the window ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Privileged write strobe for the permission table |
| cfg_app | input | APP_W | Application whose row is written |
| cfg_row | input | N_PERIPH | Permitted-peripheral bits for that application |
| app_id | input | APP_W | ID of the running application |
| sel_we | input | 1 | Application write strobe for the select register |
| sel_data | input | N_PERIPH | Requested peripheral set |
| ctx_we | input | 1 | Privileged context-restore strobe |
| ctx_wdata | input | N_PERIPH | Select value restored on a context switch |
| ctx_rdata | output | N_PERIPH | Current select value, read on a context save |
| scl_in | input | 1 | Sampled clock line of the bus |
| sda_in | input | 1 | Sampled data line of the bus |
| panic | input | 1 | Forces the select register clear and resets active devices |
| sda_oe_n | output | N_PERIPH | Active-low data-line enable per peripheral |
| scl_oe_n | output | N_PERIPH | Active-low clock-line enable per peripheral |
| dev_rst | output | N_PERIPH | Reset request per peripheral |
| sec_exc_perm | output | 1 | Pulse on a rejected select write |
| sec_exc_len | output | 1 | Pulse on an over-long transaction |

## Verification
The bench sweeps every select value against every application's row. This catches a guard that keeps a rejected value, misses the exception, or gates with the select value alone so that a peripheral outside the row reaches the bus. It places a STOP at exactly the last allowed edge and also lets a transaction run one edge past it. An off-by-one counter shows up either as a false exception or as a late one. SDA toggles while SCL is low must not start the timer, or the guard would fire on plain data bits. The panic test rewrites the select register inside the reset window. A guard that does not hold the enables high during that window would put a peripheral back on the bus while it is still being reset.

// File: rtl/pbg_pkg.sv
package pbg_pkg;

    typedef struct packed {
        logic scl;
        logic sda;
    } line_t;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_START = 2'd1,
        EV_STOP  = 2'd2
    } line_ev_t;

    localparam line_t LINE_IDLE = '{scl: 1'b1, sda: 1'b1};

    // Classify the change between two successive samples of the bus lines.
    function automatic line_ev_t classify(line_t prev, line_t cur);
        line_ev_t ev;
        ev = EV_NONE;
        if (prev.scl && cur.scl) begin
            if (prev.sda && !cur.sda)
                ev = EV_START;
            else if (!prev.sda && cur.sda)
                ev = EV_STOP;
        end
        return ev;
    endfunction

endpackage

// File: rtl/pbg_acl_map.sv
module pbg_acl_map #(
    parameter int N_APPS   = 4,
    parameter int N_PERIPH = 4,
    parameter int APP_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [APP_W-1:0]    wr_app,
    input  logic [N_PERIPH-1:0] wr_row,
    input  logic [APP_W-1:0]    rd_app,
    output logic [N_PERIPH-1:0] rd_row
);
    logic [N_PERIPH-1:0] rows [N_APPS];

    generate
        for (genvar a = 0; a < N_APPS; a++) begin : g_row
            always_ff @(posedge clk) begin
                if (rst)
                    rows[a] <= '0;
                else if (wr_en && (int'(wr_app) == a))
                    rows[a] <= wr_row;
            end
        end
    endgenerate

    always_comb begin
        rd_row = '0;
        for (int a = 0; a < N_APPS; a++)
            if (int'(rd_app) == a)
                rd_row = rows[a];
    end

    // R2: a table write is visible on the same address the next cycle
    p_row_write_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (int'(wr_app) < N_APPS)) |=> (rows[$past(wr_app)] == $past(wr_row)));

endmodule

// File: rtl/pbg_sel_reg.sv
module pbg_sel_reg #(
    parameter int N_PERIPH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [N_PERIPH-1:0] row,
    input  logic                app_we,
    input  logic [N_PERIPH-1:0] app_data,
    input  logic                priv_we,
    input  logic [N_PERIPH-1:0] priv_data,
    output logic [N_PERIPH-1:0] sel,
    output logic                deny_pulse
);
    logic outside;
    assign outside = |(app_data & ~row);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel        <= '0;
            deny_pulse <= 1'b0;
        end else begin
            deny_pulse <= 1'b0;
            if (clear)
                sel <= '0;
            else if (priv_we)
                sel <= priv_data;
            else if (app_we) begin
                if (outside)
                    deny_pulse <= 1'b1;
                else
                    sel <= app_data;
            end
        end
    end

    // R3: a rejected write leaves the register untouched
    p_deny_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (app_we && !priv_we && !clear && outside) |=> $stable(sel));

    // R3: a rejected write raises the permission exception next cycle
    p_deny_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (app_we && !priv_we && !clear && outside) |=> deny_pulse);

    // R5: a privileged restore never raises the exception
    p_priv_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        priv_we |=> !deny_pulse);

endmodule

// File: rtl/pbg_txn_watch.sv
module pbg_txn_watch
    import pbg_pkg::*;
#(
    parameter int TXN_LIMIT = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic scl,
    input  logic sda,
    output logic overrun
);
    localparam int CNT_W = $clog2(TXN_LIMIT + 1);

    line_t          prev, cur;
    line_ev_t       ev;
    logic           busy;
    logic [CNT_W-1:0] cnt;

    assign cur = '{scl: scl, sda: sda};
    assign ev  = classify(prev, cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev    <= LINE_IDLE;
            busy    <= 1'b0;
            cnt     <= '0;
            overrun <= 1'b0;
        end else begin
            prev    <= cur;
            overrun <= 1'b0;
            case (ev)
                EV_START: begin
                    busy <= 1'b1;
                    cnt  <= '0;
                end
                EV_STOP: begin
                    busy <= 1'b0;
                    cnt  <= '0;
                end
                default: begin
                    if (busy) begin
                        if (cnt == CNT_W'(TXN_LIMIT - 1)) begin
                            overrun <= 1'b1;
                            busy    <= 1'b0;
                            cnt     <= '0;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    // R7: an overrun only follows an open transaction
    p_len_needs_busy_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |-> $past(busy));

    // R7: the length exception is a single-cycle pulse
    p_len_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        overrun |=> !overrun);

    // R6: a STOP always closes the transaction
    p_stop_closes_r6: assert property (@(posedge clk) disable iff (rst)
        (ev == EV_STOP) |=> !busy);

endmodule

// File: rtl/pbg_dev_reset.sv
module pbg_dev_reset #(
    parameter int N_PERIPH   = 4,
    parameter int RST_CYCLES = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                panic,
    input  logic [N_PERIPH-1:0] active,
    output logic [N_PERIPH-1:0] dev_rst
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    logic [N_PERIPH-1:0] mask;
    logic [RC_W-1:0]     remain;
    logic                in_window;

    assign in_window = (remain != '0);
    assign dev_rst   = in_window ? mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '0;
            remain <= '0;
        end else if (panic) begin
            mask   <= (in_window ? mask : '0) | active;
            remain <= RC_W'(RST_CYCLES);
        end else if (in_window) begin
            remain <= remain - 1'b1;
        end
    end

    // R8: every peripheral active at panic is put in reset
    p_panic_capture_r8: assert property (@(posedge clk) disable iff (rst)
        panic |=> ((dev_rst & $past(active)) == $past(active)));

    // R8: the window never exceeds its programmed length
    p_window_bound_r8: assert property (@(posedge clk) disable iff (rst)
        (!panic && in_window) |=> (remain < $past(remain)));

endmodule

// File: rtl/periph_bus_guard.sv
module periph_bus_guard #(
    parameter int N_APPS     = 4,
    parameter int N_PERIPH   = 4,
    parameter int TXN_LIMIT  = 64,
    parameter int RST_CYCLES = 8,
    parameter int APP_W      = (N_APPS > 1) ? $clog2(N_APPS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [APP_W-1:0]    cfg_app,
    input  logic [N_PERIPH-1:0] cfg_row,
    input  logic [APP_W-1:0]    app_id,
    input  logic                sel_we,
    input  logic [N_PERIPH-1:0] sel_data,
    input  logic                ctx_we,
    input  logic [N_PERIPH-1:0] ctx_wdata,
    output logic [N_PERIPH-1:0] ctx_rdata,
    input  logic                scl_in,
    input  logic                sda_in,
    input  logic                panic,
    output logic [N_PERIPH-1:0] sda_oe_n,
    output logic [N_PERIPH-1:0] scl_oe_n,
    output logic [N_PERIPH-1:0] dev_rst,
    output logic                sec_exc_perm,
    output logic                sec_exc_len
);
    logic [N_PERIPH-1:0] cur_row;
    logic [N_PERIPH-1:0] sel;
    logic [N_PERIPH-1:0] granted;
    logic [N_PERIPH-1:0] live;
    logic                wipe;

    pbg_acl_map #(.N_APPS(N_APPS), .N_PERIPH(N_PERIPH), .APP_W(APP_W)) u_map (
        .clk(clk), .rst(rst),
        .wr_en(cfg_we), .wr_app(cfg_app), .wr_row(cfg_row),
        .rd_app(app_id), .rd_row(cur_row)
    );

    assign wipe = panic | sec_exc_len;

    pbg_sel_reg #(.N_PERIPH(N_PERIPH)) u_sel (
        .clk(clk), .rst(rst), .clear(wipe), .row(cur_row),
        .app_we(sel_we), .app_data(sel_data),
        .priv_we(ctx_we), .priv_data(ctx_wdata),
        .sel(sel), .deny_pulse(sec_exc_perm)
    );

    pbg_txn_watch #(.TXN_LIMIT(TXN_LIMIT)) u_watch (
        .clk(clk), .rst(rst), .scl(scl_in), .sda(sda_in), .overrun(sec_exc_len)
    );

    assign granted = cur_row & sel;

    pbg_dev_reset #(.N_PERIPH(N_PERIPH), .RST_CYCLES(RST_CYCLES)) u_rst (
        .clk(clk), .rst(rst), .panic(panic), .active(granted), .dev_rst(dev_rst)
    );

    assign live      = granted & ~dev_rst;
    assign sda_oe_n  = ~live;
    assign scl_oe_n  = ~live;
    assign ctx_rdata = sel;

    // R1: nothing may drive the bus right after reset
    p_idle_after_reset_r1: assert property (@(posedge clk)
        rst |=> ((&sda_oe_n) && (&scl_oe_n) && (dev_rst == '0)));

    // R9: a peripheral in reset never has its enables low
    p_reset_gate_r9: assert property (@(posedge clk) disable iff (rst)
        ((dev_rst & ~(sda_oe_n & scl_oe_n)) == '0));

    // R4: no enable outside the running application's row
    p_row_bound_r4: assert property (@(posedge clk) disable iff (rst)
        ((~sda_oe_n & ~cur_row) == '0));

    // R7: an over-long transaction empties the select register
    p_len_clears_r7: assert property (@(posedge clk) disable iff (rst)
        sec_exc_len |=> (ctx_rdata == '0));

endmodule

// File: tb/periph_bus_guard_bench.sv
module periph_bus_guard_bench;
    localparam int NA  = 4;
    localparam int NP  = 4;
    localparam int LIM = 16;
    localparam int RC  = 3;
    localparam int AW  = 2;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [AW-1:0] cfg_app = '0;
    logic [NP-1:0] cfg_row = '0;
    logic [AW-1:0] app_id = '0;
    logic          sel_we = 1'b0;
    logic [NP-1:0] sel_data = '0;
    logic          ctx_we = 1'b0;
    logic [NP-1:0] ctx_wdata = '0;
    logic [NP-1:0] ctx_rdata;
    logic          scl_in = 1'b1;
    logic          sda_in = 1'b1;
    logic          panic = 1'b0;
    logic [NP-1:0] sda_oe_n, scl_oe_n, dev_rst;
    logic          sec_exc_perm, sec_exc_len;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    periph_bus_guard #(.N_APPS(NA), .N_PERIPH(NP), .TXN_LIMIT(LIM),
                       .RST_CYCLES(RC), .APP_W(AW)) u_periph_bus_guard (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_app(cfg_app), .cfg_row(cfg_row),
        .app_id(app_id), .sel_we(sel_we), .sel_data(sel_data),
        .ctx_we(ctx_we), .ctx_wdata(ctx_wdata), .ctx_rdata(ctx_rdata),
        .scl_in(scl_in), .sda_in(sda_in), .panic(panic),
        .sda_oe_n(sda_oe_n), .scl_oe_n(scl_oe_n), .dev_rst(dev_rst),
        .sec_exc_perm(sec_exc_perm), .sec_exc_len(sec_exc_len)
    );

    function automatic int row_of(int a);
        return (a * 7 + 5) % 16;
    endfunction

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic chk_gate(string tag, int exp_oe_n);
        chk({tag, " sda_oe_n"}, int'(sda_oe_n), exp_oe_n);
        chk({tag, " scl_oe_n"}, int'(scl_oe_n), exp_oe_n);
    endtask

    initial begin
        int exp_sel;
        int row;
        tick(); tick();
        // R1 reset state
        chk_gate("R1", 'hF);
        chk("R1 dev_rst", int'(dev_rst), 0);
        chk("R1 perm", int'(sec_exc_perm), 0);
        chk("R1 len", int'(sec_exc_len), 0);
        chk("R1 ctx_rdata", int'(ctx_rdata), 0);
        rst = 1'b0;
        // R1: empty table rejects any select value
        sel_we = 1'b1; sel_data = 4'h1; tick(); sel_we = 1'b0;
        chk("R1 empty row perm", int'(sec_exc_perm), 1);
        chk_gate("R1 empty row", 'hF);

        // R2 program the table
        for (int a = 0; a < NA; a++) begin
            cfg_we = 1'b1; cfg_app = AW'(a); cfg_row = NP'(row_of(a)); tick();
        end
        cfg_we = 1'b0;

        // R3/R4/R5 sweep every select value for every application
        for (int a = 0; a < NA; a++) begin
            app_id = AW'(a);
            row = row_of(a);
            ctx_we = 1'b1; ctx_wdata = '0; tick(); ctx_we = 1'b0;
            exp_sel = 0;
            for (int s = 0; s < 16; s++) begin
                sel_we = 1'b1; sel_data = NP'(s); tick(); sel_we = 1'b0;
                if ((s & ~row & 'hF) != 0) begin
                    chk("R3 reject flag", int'(sec_exc_perm), 1);
                end else begin
                    chk("R3 accept flag", int'(sec_exc_perm), 0);
                    exp_sel = s;
                end
                chk("R3 select value", int'(ctx_rdata), exp_sel);
                chk_gate("R4 sweep", (~(row & exp_sel)) & 'hF);
            end
        end

        // R5 restore wins over application write, unchecked
        app_id = AW'(1);
        ctx_we = 1'b1; ctx_wdata = 4'hF; sel_we = 1'b1; sel_data = 4'h0; tick();
        ctx_we = 1'b0; sel_we = 1'b0;
        chk("R5 restore value", int'(ctx_rdata), 'hF);
        chk("R5 no flag", int'(sec_exc_perm), 0);
        chk_gate("R5 masked by row", (~row_of(1)) & 'hF);
        // R4 switching app_id acts at once
        app_id = AW'(2); #1;
        chk_gate("R4 app switch", (~row_of(2)) & 'hF);
        app_id = AW'(1);
        // R2/R4 shrinking a row
        cfg_we = 1'b1; cfg_app = AW'(1); cfg_row = 4'h4; tick();
        cfg_app = AW'(3); cfg_row = 4'h1; tick(); cfg_we = 1'b0;
        chk_gate("R2 row shrink", 'hB);
        app_id = AW'(3); #1;
        chk_gate("R2 other row", 'hE);
        app_id = AW'(1);
        cfg_we = 1'b1; cfg_app = AW'(1); cfg_row = NP'(row_of(1)); tick();
        cfg_app = AW'(3); cfg_row = NP'(row_of(3)); tick(); cfg_we = 1'b0;

        // R6/R7 STOP on the last allowed edge
        sda_in = 1'b0; tick();
        for (int i = 1; i < LIM; i++) begin
            tick(); chk("R7 within limit", int'(sec_exc_len), 0);
        end
        sda_in = 1'b1; tick();
        chk("R7 stop at limit", int'(sec_exc_len), 0);
        tick();
        chk("R7 stop at limit later", int'(sec_exc_len), 0);
        chk("R7 select kept", int'(ctx_rdata), 'hF);

        // R6 data toggles with SCL low are not START
        scl_in = 1'b0; tick(); sda_in = 1'b0; tick(); scl_in = 1'b1; tick();
        for (int i = 0; i < LIM + 3; i++) begin
            tick(); chk("R6 no false start", int'(sec_exc_len), 0);
        end
        scl_in = 1'b0; tick(); sda_in = 1'b1; tick(); scl_in = 1'b1; tick();

        // R7 overrun by one edge
        sda_in = 1'b0; tick();
        for (int i = 1; i <= LIM; i++) begin
            tick(); chk("R7 overrun timing", int'(sec_exc_len), (i == LIM) ? 1 : 0);
        end
        tick();
        chk("R7 pulse ends", int'(sec_exc_len), 0);
        chk("R7 select cleared", int'(ctx_rdata), 0);
        chk_gate("R7 bus cut off", 'hF);
        sda_in = 1'b1; tick();

        // R8/R9 panic with rewrite inside the window
        app_id = AW'(3);
        sel_we = 1'b1; sel_data = 4'h8; tick(); sel_we = 1'b0;
        chk_gate("R4 before panic", 'h7);
        panic = 1'b1; tick(); panic = 1'b0;
        for (int i = 0; i < RC; i++) begin
            chk("R8 dev_rst", int'(dev_rst), 'h8);
            if (i == 0) begin
                chk("R8 select cleared", int'(ctx_rdata), 0);
                chk_gate("R9 window start", 'hF);
                sel_we = 1'b1; sel_data = 4'hA;
            end else begin
                chk_gate("R9 held in reset", 'hD);
            end
            tick();
            sel_we = 1'b0;
        end
        chk("R8 window over", int'(dev_rst), 0);
        chk_gate("R9 released", 'h5);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule